// File: doc/BRIEF.md
# Parallel-Bus to Serial FRAM Memory Bridge

This block connects the parallel memory bus of a small CPU to an external serial FRAM. The chip then needs no internal RAM. On the processor side it is a Wishbone slave that takes word-addressed read and write cycles with per-byte lane selects. On the memory side it is a four-wire SPI master. Every bus request becomes one serial command frame, or two frames for a store. The bus acknowledge is held back until the last frame has ended. The bridge keeps no memory array of its own. It latches the request, builds the frame, shifts it out and reassembles the returned bytes.

Loads always fetch a whole aligned word, and the CPU picks out the lanes it needs. A store first sends a separate write-enable command. It then sends a write command that starts at the lowest selected byte and carries only the selected bytes, so that the device's address auto-increment covers exactly the lanes being changed. Serial clock runs at half the system clock in SPI mode 0.

Top module: `membus_serial_bridge`

## Requirements
- R1: In reset and while idle, chip select (`spi_csn`) is high, `spi_sclk` is low and `wb_ack_o` is low.
- R2: `spi_sclk` is high only while `spi_csn` is low. Each high phase lasts exactly one system clock, so the serial clock runs at half the system rate.
- R3: A read sends one frame within a single chip-select-low period, lasting 64 serial clocks. The frame carries the 8-bit command 0x03, then a 24-bit byte address equal to the request address with its two lowest bits cleared, then 32 clocks of read data. Every field goes MSB first.
- R4: Read data is little-endian. The first byte received (lowest address) lands in bits 7:0 of `wb_dat_o` and the fourth in bits 31:24. Each byte arrives MSB first on `spi_miso` and is sampled when `spi_sclk` rises.
- R5: Every store is preceded by its own 8-clock frame carrying command 0x06. Chip select returns high for at least one system clock between that frame and the write frame.
- R6: The write frame carries command 0x02, then a start address equal to the word address plus the index of the lowest set bit of `wb_sel_i`, then only the selected bytes in ascending lane order. It lasts 32+8n serial clocks for n selected bytes. Legal selects are 0001, 0010, 0100, 1000, 0011, 1100 and 1111.
- R7: A partial store leaves the memory bytes of the unselected lanes unchanged.
- R8: `wb_ack_o` is high for exactly one cycle per request, in the first cycle in which chip select is high after the last frame. Count the edge that first samples `wb_cyc_i`&`wb_stb_i` as edge 1. Acknowledge is then visible after edge 129 for a read and after edge 82+16n for an n-byte store.
- R9: In SPI mode 0, `spi_mosi` changes only at the system edge where `spi_sclk` falls or where a frame is loaded, and never while `spi_sclk` is high.
- R10: The request is latched when it is accepted. Changing the address, write data or select inputs before the acknowledge has no effect on the frames sent or the data stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write request when high |
| wb_adr_i | input | ADR_W (24) | Byte address (low two bits ignored) |
| wb_dat_i | input | DAT_W (32) | Store data, lane k in bits 8k+7:8k |
| wb_sel_i | input | DAT_W/8 (4) | Byte lane selects |
| wb_dat_o | output | DAT_W (32) | Load data, valid with acknowledge |
| wb_ack_o | output | 1 | One-cycle completion pulse |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to memory |
| spi_csn | output | 1 | Active-low chip select |
| spi_miso | input | 1 | Serial data from memory |

## Verification
A wrong frame length or a wrong lane plan shows up within one transaction. The memory model sees a frame with the wrong clock count, a start address that is off, or bytes written into neighbouring lanes. These are visible well before the acknowledge that the bench times to the exact edge. A controller stuck in the wrong state shows up the same way: a store with no write-enable frame before it, a chip select that never rises, or an acknowledge arriving early, late or twice. Byte-order faults in the read path appear as swapped lanes in the first load that follows a known store.

// File: rtl/msb_pkg.sv
package msb_pkg;

    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_WREN  = 8'h06;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WREN,
        ST_GAP,
        ST_XFER,
        ST_ACK
    } bstate_e;

    typedef struct packed {
        logic [2:0] first;
        logic [2:0] count;
    } lane_plan_t;

endpackage

// File: rtl/msb_lane_plan.sv
module msb_lane_plan
    import msb_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [LANES-1:0] sel,
    output lane_plan_t       plan
);

    always_comb begin
        plan.first = '0;
        plan.count = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (sel[i]) begin
                plan.first = 3'(i);
                plan.count = plan.count + 3'd1;
            end
        end
    end

endmodule

// File: rtl/msb_spi_shifter.sv
module msb_spi_shifter #(
    parameter int FRAME_W = 64,
    parameter int RX_W    = 32,
    parameter int CNT_W   = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [FRAME_W-1:0] frame,
    input  logic [CNT_W-1:0]   nbits,
    input  logic               miso,
    output logic               sclk,
    output logic               mosi,
    output logic               done,
    output logic [RX_W-1:0]    rx
);

    logic [FRAME_W-1:0] tx_q;
    logic [RX_W-1:0]    rx_q;
    logic [CNT_W-1:0]   left_q;
    logic               busy_q;
    logic               sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q   <= '0;
            rx_q   <= '0;
            left_q <= '0;
            busy_q <= 1'b0;
            sclk_q <= 1'b0;
        end else if (start && !busy_q) begin
            tx_q   <= frame;
            left_q <= nbits;
            busy_q <= 1'b1;
            sclk_q <= 1'b0;
        end else if (busy_q) begin
            if (!sclk_q) begin
                sclk_q <= 1'b1;
                rx_q   <= {rx_q[RX_W-2:0], miso};
            end else begin
                sclk_q <= 1'b0;
                tx_q   <= tx_q << 1;
                left_q <= left_q - 1'b1;
                if (left_q == CNT_W'(1)) begin
                    busy_q <= 1'b0;
                end
            end
        end
    end

    assign done = busy_q && sclk_q && (left_q == CNT_W'(1));
    assign sclk = sclk_q;
    assign mosi = tx_q[FRAME_W-1];
    assign rx   = rx_q;

endmodule

// File: rtl/membus_serial_bridge.sv
module membus_serial_bridge
    import msb_pkg::*;
#(
    parameter int ADR_W = 24,
    parameter int DAT_W = 32,
    parameter int CMD_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wb_cyc_i,
    input  logic               wb_stb_i,
    input  logic               wb_we_i,
    input  logic [ADR_W-1:0]   wb_adr_i,
    input  logic [DAT_W-1:0]   wb_dat_i,
    input  logic [DAT_W/8-1:0] wb_sel_i,
    output logic [DAT_W-1:0]   wb_dat_o,
    output logic               wb_ack_o,
    output logic               spi_sclk,
    output logic               spi_mosi,
    output logic               spi_csn,
    input  logic               spi_miso
);

    localparam int LANES   = DAT_W / 8;
    localparam int LB      = $clog2(LANES);
    localparam int HDR_W   = CMD_W + ADR_W;
    localparam int FRAME_W = HDR_W + DAT_W;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    bstate_e             state;
    logic [ADR_W-LB-1:0] r_wadr;
    logic [DAT_W-1:0]    r_dat;
    logic [LANES-1:0]    r_sel;
    logic                r_we;
    logic                csn_q;
    logic [DAT_W-1:0]    rdat_q;

    lane_plan_t          plan;
    logic [ADR_W-1:0]    wr_adr;
    logic [DAT_W-1:0]    lane_shift;
    logic [DAT_W-1:0]    wr_payload;
    logic [DAT_W-1:0]    rd_word;
    logic [DAT_W-1:0]    sh_rx;
    logic [FRAME_W-1:0]  wren_frame;
    logic [FRAME_W-1:0]  rd_frame;
    logic [FRAME_W-1:0]  wr_frame;
    logic [CNT_W-1:0]    wr_bits;
    logic                sh_start;
    logic [FRAME_W-1:0]  sh_frame;
    logic [CNT_W-1:0]    sh_nbits;
    logic                sh_done;
    logic                req;
    logic                unused_adr_lsb;

    assign req            = wb_cyc_i && wb_stb_i;
    assign unused_adr_lsb = ^wb_adr_i[LB-1:0];

    msb_lane_plan #(.LANES(LANES)) u_plan (
        .sel  (r_sel),
        .plan (plan)
    );

    // Start address of a store: word address plus lowest selected lane.
    assign wr_adr     = {r_wadr, LB'(plan.first)};
    assign lane_shift = r_dat >> (8 * plan.first);

    // Byte k goes out k-th; the k-th byte received belongs in lane k.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign wr_payload[DAT_W-1-8*k -: 8] = lane_shift[8*k +: 8];
        assign rd_word[8*k +: 8]            = sh_rx[DAT_W-1-8*k -: 8];
    end

    assign wren_frame = {CMD_W'(OP_WREN), {(FRAME_W-CMD_W){1'b0}}};
    assign rd_frame   = {CMD_W'(OP_READ), wb_adr_i[ADR_W-1:LB], {LB{1'b0}}, {DAT_W{1'b0}}};
    assign wr_frame   = {CMD_W'(OP_WRITE), wr_adr, wr_payload};
    assign wr_bits    = CNT_W'(HDR_W) + CNT_W'({plan.count, 3'b000});

    always_comb begin
        sh_start = 1'b0;
        sh_frame = '0;
        sh_nbits = '0;
        case (state)
            ST_IDLE: begin
                sh_start = req;
                sh_frame = wb_we_i ? wren_frame : rd_frame;
                sh_nbits = wb_we_i ? CNT_W'(CMD_W) : CNT_W'(FRAME_W);
            end
            ST_GAP: begin
                sh_start = 1'b1;
                sh_frame = wr_frame;
                sh_nbits = wr_bits;
            end
            default: ;
        endcase
    end

    msb_spi_shifter #(
        .FRAME_W (FRAME_W),
        .RX_W    (DAT_W),
        .CNT_W   (CNT_W)
    ) u_shift (
        .clk   (clk),
        .rst   (rst),
        .start (sh_start),
        .frame (sh_frame),
        .nbits (sh_nbits),
        .miso  (spi_miso),
        .sclk  (spi_sclk),
        .mosi  (spi_mosi),
        .done  (sh_done),
        .rx    (sh_rx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            r_wadr <= '0;
            r_dat  <= '0;
            r_sel  <= '0;
            r_we   <= 1'b0;
            csn_q  <= 1'b1;
            rdat_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req) begin
                        r_wadr <= wb_adr_i[ADR_W-1:LB];
                        r_dat  <= wb_dat_i;
                        r_sel  <= wb_sel_i;
                        r_we   <= wb_we_i;
                        csn_q  <= 1'b0;
                        state  <= wb_we_i ? ST_WREN : ST_XFER;
                    end
                end
                ST_WREN: begin
                    if (sh_done) begin
                        csn_q <= 1'b1;
                        state <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    csn_q <= 1'b0;
                    state <= ST_XFER;
                end
                ST_XFER: begin
                    if (sh_done) begin
                        csn_q <= 1'b1;
                        if (!r_we) begin
                            rdat_q <= rd_word;
                        end
                        state <= ST_ACK;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign spi_csn  = csn_q;
    assign wb_ack_o = (state == ST_ACK);
    assign wb_dat_o = rdat_q;

endmodule

// File: rtl/msb_bridge_chk.sv
module msb_bridge_chk #(
    parameter int SEL_W = 4
) (
    input logic             clk,
    input logic             rst,
    input logic             wb_cyc_i,
    input logic             wb_stb_i,
    input logic             wb_we_i,
    input logic [SEL_W-1:0] wb_sel_i,
    input logic             wb_ack_o,
    input logic             spi_sclk,
    input logic             spi_mosi,
    input logic             spi_csn
);

    function automatic logic sel_ok(input logic [SEL_W-1:0] s);
        int n;
        int lo;
        n  = 0;
        lo = 0;
        for (int i = SEL_W - 1; i >= 0; i--) begin
            if (s[i]) begin
                n  = n + 1;
                lo = i;
            end
        end
        return (n == 1) || (n == SEL_W) ||
               ((n == 2) && (lo % 2 == 0) && s[lo+1]);
    endfunction

    // R2: each serial clock high phase lasts a single system cycle
    a_r2_sclk_pulse: assert property (@(posedge clk) disable iff (rst)
        spi_sclk |=> !spi_sclk);

    // R2: serial clock only runs inside a frame
    a_r2_sclk_in_frame: assert property (@(posedge clk) disable iff (rst)
        spi_sclk |-> !spi_csn);

    // R9: data out is held across the rising serial clock edge
    a_r9_mosi_hold: assert property (@(posedge clk) disable iff (rst)
        (spi_sclk && !spi_csn) |-> $stable(spi_mosi));

    // R8: acknowledge is a one-cycle pulse
    a_r8_ack_single: assert property (@(posedge clk) disable iff (rst)
        wb_ack_o |=> !wb_ack_o);

    // R8: acknowledge comes in the first cycle after chip select rises
    a_r8_ack_after_cs: assert property (@(posedge clk) disable iff (rst)
        wb_ack_o |-> (spi_csn && !$past(spi_csn)));

    // R6: store selects are one of the legal lane patterns
    a_r6_sel_legal: assert property (@(posedge clk) disable iff (rst)
        (wb_cyc_i && wb_stb_i && wb_we_i) |-> sel_ok(wb_sel_i));

endmodule

bind membus_serial_bridge msb_bridge_chk #(.SEL_W(DAT_W/8)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wb_cyc_i (wb_cyc_i),
    .wb_stb_i (wb_stb_i),
    .wb_we_i  (wb_we_i),
    .wb_sel_i (wb_sel_i),
    .wb_ack_o (wb_ack_o),
    .spi_sclk (spi_sclk),
    .spi_mosi (spi_mosi),
    .spi_csn  (spi_csn)
);

// File: tb/sim_membus_serial_bridge.sv
`timescale 1ns/1ps
module sim_membus_serial_bridge;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wb_cyc_i = 1'b0;
    logic        wb_stb_i = 1'b0;
    logic        wb_we_i = 1'b0;
    logic [23:0] wb_adr_i = '0;
    logic [31:0] wb_dat_i = '0;
    logic [3:0]  wb_sel_i = '0;
    logic [31:0] wb_dat_o;
    logic        wb_ack_o;
    logic        spi_sclk;
    logic        spi_mosi;
    logic        spi_csn;
    logic        spi_miso = 1'b0;

    always #2.5 clk = ~clk;

    membus_serial_bridge u0 (
        .clk      (clk),
        .rst      (rst),
        .wb_cyc_i (wb_cyc_i),
        .wb_stb_i (wb_stb_i),
        .wb_we_i  (wb_we_i),
        .wb_adr_i (wb_adr_i),
        .wb_dat_i (wb_dat_i),
        .wb_sel_i (wb_sel_i),
        .wb_dat_o (wb_dat_o),
        .wb_ack_o (wb_ack_o),
        .spi_sclk (spi_sclk),
        .spi_mosi (spi_mosi),
        .spi_csn  (spi_csn),
        .spi_miso (spi_miso)
    );

    int checks = 0;
    int fails  = 0;

    // ---------------- serial memory model ----------------
    logic [7:0]  mem [0:255];
    int          bitn = 0;
    logic [31:0] sh = '0;
    logic [7:0]  cmd = '0;
    logic [23:0] faddr = '0;
    logic [23:0] wptr = '0;
    logic        wel = 1'b0;
    int          bad_wr = 0;
    int          fcount = 0;
    logic [7:0]  fr_cmd  [0:7];
    logic [23:0] fr_addr [0:7];
    int          fr_bits [0:7];
    int          ack_cnt = 0;
    int          hi_run = 0;
    int          last_gap = 0;

    always @(negedge spi_csn) begin
        bitn = 0;
        sh   = '0;
        cmd  = '0;
    end

    always @(posedge spi_sclk) begin
        if (spi_csn === 1'b0) begin
            sh   = {sh[30:0], spi_mosi};
            bitn = bitn + 1;
            if (bitn == 8) cmd = sh[7:0];
            if (bitn == 32) begin
                faddr = sh[23:0];
                wptr  = sh[23:0];
            end
            if (bitn > 32 && bitn % 8 == 0 && cmd == 8'h02) begin
                if (wel) mem[wptr[7:0]] = sh[7:0];
                else bad_wr = bad_wr + 1;
                wptr = wptr + 24'd1;
            end
        end
    end

    always @(negedge spi_sclk) begin
        if (spi_csn === 1'b0 && cmd == 8'h03 && bitn >= 32 && bitn < 64) begin
            automatic int d = bitn - 32;
            spi_miso = mem[faddr[7:0] + 8'(d / 8)][7 - (d % 8)];
        end
    end

    always @(posedge spi_csn) begin
        if (fcount < 8) begin
            fr_cmd[fcount]  = cmd;
            fr_addr[fcount] = faddr;
            fr_bits[fcount] = bitn;
        end
        fcount = fcount + 1;
        if (cmd == 8'h06 && bitn == 8) wel = 1'b1;
        else if (cmd == 8'h02) wel = 1'b0;
    end

    always @(posedge clk) begin
        if (wb_ack_o === 1'b1) ack_cnt = ack_cnt + 1;
        if (spi_csn === 1'b1) hi_run = hi_run + 1;
        else begin
            if (hi_run > 0) last_gap = hi_run;
            hi_run = 0;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // perturb: 1 = change address/data inputs mid-request
    task automatic bus(input bit we, input logic [23:0] adr, input logic [31:0] dat,
                       input logic [3:0] sel, input bit perturb,
                       output logic [31:0] rd, output int lat);
        fcount  = 0;
        ack_cnt = 0;
        rd      = '0;
        @(negedge clk);
        wb_cyc_i = 1'b1;
        wb_stb_i = 1'b1;
        wb_we_i  = we;
        wb_adr_i = adr;
        wb_dat_i = dat;
        wb_sel_i = sel;
        lat = 0;
        forever begin
            @(negedge clk);
            lat = lat + 1;
            if (perturb && lat == 5) begin
                wb_adr_i = adr ^ 24'h000030;
                wb_dat_i = ~dat;
            end
            if (wb_ack_o) begin
                rd = wb_dat_o;
                break;
            end
            if (lat > 2000) break;
        end
        wb_cyc_i = 1'b0;
        wb_stb_i = 1'b0;
        wb_we_i  = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(spi_csn === 1'b1, "R1 csn idle", 32'(spi_csn), 1);
        chk(spi_sclk === 1'b0, "R1 sclk idle", 32'(spi_sclk), 0);
        chk(wb_ack_o === 1'b0, "R1 ack idle", 32'(wb_ack_o), 0);
    endtask

    task automatic t_read_word();
        logic [31:0] rd;
        int lat;
        mem[8'h10] = 8'h11; mem[8'h11] = 8'h22;
        mem[8'h12] = 8'h33; mem[8'h13] = 8'h44;
        bus(1'b0, 24'h000010, '0, 4'hF, 1'b0, rd, lat);
        chk(rd == 32'h44332211, "R4 read word", rd, 32'h44332211);
        chk(fcount == 1, "R3 one frame", 32'(fcount), 1);
        chk(fr_cmd[0] == 8'h03, "R3 read cmd", 32'(fr_cmd[0]), 32'h03);
        chk(fr_bits[0] == 64, "R3 read length", 32'(fr_bits[0]), 64);
        chk(fr_addr[0] == 24'h10, "R3 read address", 32'(fr_addr[0]), 32'h10);
        chk(lat == 129, "R8 read latency", 32'(lat), 129);
        chk(ack_cnt == 1, "R8 single ack", 32'(ack_cnt), 1);
        chk(spi_csn === 1'b1 && spi_sclk === 1'b0, "R1 idle after read",
            {30'd0, spi_csn, spi_sclk}, 32'h2);
    endtask

    task automatic t_read_unaligned();
        logic [31:0] rd;
        int lat;
        bus(1'b0, 24'h000012, '0, 4'hF, 1'b0, rd, lat);
        chk(fr_addr[0] == 24'h10, "R3 low bits cleared", 32'(fr_addr[0]), 32'h10);
        chk(rd == 32'h44332211, "R4 unaligned read data", rd, 32'h44332211);
    endtask

    task automatic t_write_word();
        logic [31:0] rd;
        int lat;
        bus(1'b1, 24'h000020, 32'hA1B2C3D4, 4'hF, 1'b0, rd, lat);
        chk(fcount == 2, "R5 two frames", 32'(fcount), 2);
        chk(fr_cmd[0] == 8'h06 && fr_bits[0] == 8, "R5 enable frame",
            {fr_cmd[0], 24'(fr_bits[0])}, {8'h06, 24'd8});
        chk(last_gap >= 1, "R5 cs gap", 32'(last_gap), 1);
        chk(bad_wr == 0, "R5 write enabled", 32'(bad_wr), 0);
        chk(fr_cmd[1] == 8'h02 && fr_bits[1] == 64, "R6 write frame",
            {fr_cmd[1], 24'(fr_bits[1])}, {8'h02, 24'd64});
        chk(fr_addr[1] == 24'h20, "R6 word address", 32'(fr_addr[1]), 32'h20);
        chk({mem[8'h23], mem[8'h22], mem[8'h21], mem[8'h20]} == 32'hA1B2C3D4,
            "R6 stored word", {mem[8'h23], mem[8'h22], mem[8'h21], mem[8'h20]},
            32'hA1B2C3D4);
        chk(lat == 146, "R8 word store latency", 32'(lat), 146);
        chk(ack_cnt == 1, "R8 single ack store", 32'(ack_cnt), 1);
        bus(1'b0, 24'h000020, '0, 4'hF, 1'b0, rd, lat);
        chk(rd == 32'hA1B2C3D4, "R4 read back word", rd, 32'hA1B2C3D4);
    endtask

    task automatic t_partial();
        logic [3:0] sels [0:5];
        sels[0] = 4'b0001; sels[1] = 4'b0010; sels[2] = 4'b0100;
        sels[3] = 4'b1000; sels[4] = 4'b0011; sels[5] = 4'b1100;
        for (int i = 0; i < 6; i++) begin
            automatic logic [7:0]  base = 8'h40 + 8'(16 * i);
            automatic logic [31:0] dat  = 32'h87654321;
            automatic logic [31:0] expw;
            automatic int          first = 0;
            automatic int          n = 0;
            logic [31:0] rd;
            int lat;
            for (int j = 3; j >= 0; j--) begin
                mem[base + 8'(j)] = 8'hE0 + 8'(j);
                if (sels[i][j]) begin first = j; n = n + 1; end
            end
            for (int j = 0; j < 4; j++) begin
                expw[8*j +: 8] = sels[i][j] ? dat[8*j +: 8] : 8'hE0 + 8'(j);
            end
            bus(1'b1, {16'd0, base}, dat, sels[i], 1'b0, rd, lat);
            chk(fr_addr[1] == 24'(base) + 24'(first), "R6 start lane address",
                32'(fr_addr[1]), 32'(base) + 32'(first));
            chk(fr_bits[1] == 32 + 8 * n, "R6 partial length",
                32'(fr_bits[1]), 32'(32 + 8 * n));
            chk(lat == 82 + 16 * n, "R8 partial latency", 32'(lat), 32'(82 + 16 * n));
            chk({mem[base+3], mem[base+2], mem[base+1], mem[base]} == expw,
                "R7 unselected lanes kept",
                {mem[base+3], mem[base+2], mem[base+1], mem[base]}, expw);
            bus(1'b0, {16'd0, base}, '0, 4'hF, 1'b0, rd, lat);
            chk(rd == expw, "R7 read back partial", rd, expw);
        end
    endtask

    task automatic t_latched();
        logic [31:0] rd;
        int lat;
        bus(1'b0, 24'h000010, '0, 4'hF, 1'b1, rd, lat);
        chk(fr_addr[0] == 24'h10, "R10 read address latched", 32'(fr_addr[0]), 32'h10);
        chk(rd == 32'h44332211, "R10 read data latched", rd, 32'h44332211);
        bus(1'b1, 24'h0000A0, 32'h0F1E2D3C, 4'hF, 1'b1, rd, lat);
        chk(fr_addr[1] == 24'hA0, "R10 store address latched", 32'(fr_addr[1]), 32'hA0);
        chk({mem[8'hA3], mem[8'hA2], mem[8'hA1], mem[8'hA0]} == 32'h0F1E2D3C,
            "R10 store data latched",
            {mem[8'hA3], mem[8'hA2], mem[8'hA1], mem[8'hA0]}, 32'h0F1E2D3C);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        checks = checks + 1;
        fails  = fails + 1;
        $display("FAIL R8 watchdog actual=hung expected=completion");
        finish_run();
    end

    initial begin
        for (int a = 0; a < 256; a++) mem[a] = 8'(a);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        fcount = 0;
        t_reset();
        t_read_word();
        t_read_unaligned();
        t_write_word();
        t_partial();
        t_latched();
        finish_run();
    end

endmodule